// File: doc/BRIEF.md
# Triple-Page Frame Buffer Arbiter

This block shares one single-port, SRAM-like memory between two streams: a pixel writer that drains a capture FIFO into memory, and a host reader that refills an upload FIFO from memory. A three-state ownership token decides which side may issue accesses. The token is either free, held by the writer, or held by the reader. The side that holds it runs back-to-back accesses until its request drops. Then the access in flight finishes and the token returns to free.

Each side keeps its own linear word pointer. Three page registers name the page the writer fills, the page holding the last complete frame, and the page the host is reading. Frame-complete and upload-start events rotate these registers, so a frame that is being read out is never overwritten. Each memory address is the side's page register (upper bits) joined to that side's pointer (lower bits).

On the memory side, each access is a one-cycle read or write strobe. The memory then pulls `mem_done` low and raises it again when the access ends. Read data is taken in the cycle in which `mem_done` is seen rising. The writer FIFO is expected to show its head word on `wr_fifo_data` (first-word fall-through).

Top module: `fbuf_page_arbiter`

## Requirements
- R1: After reset the token is free, no strobe, pop or push is active, both pointers are 0, and the page registers hold writer = 0, complete = 1, reader = 2.
- R2: When the token is free and `wr_dump_req` is high, the writer takes the token on the next cycle, even if the reader requests in the same cycle.
- R3: A side that finds the token held by the other side waits. The token never passes directly from one side to the other. It is released only after the holder's request has dropped and its access in flight has completed (`mem_done` rose).
- R4: A write access pops the writer FIFO in the capture cycle. On the next cycle it drives a one-cycle `mem_wr` with address {writer page, writer pointer} and the captured word. The address stays stable, and no new strobe is issued, until `mem_done` rises.
- R5: The writer pointer advances by one for each write. It returns to 0 on `frame_start` and saturates at FRAME_WORDS-1, so it stays inside its page.
- R6: A read access drives a one-cycle `mem_rd` at {reader page, reader pointer}. The read data present when `mem_done` rises is pushed to the reader FIFO on the following cycle, in address order.
- R7: `upload_go` loads the reader pointer with `upload_first` and arms the upload. The read at `upload_last` is the final one: the pointer then clears to 0 and no further reads are issued.
- R8: `upload_abort` clears the reader pointer and disarms the upload. No new read starts after it, and it takes priority over a simultaneous `upload_go`.
- R9: `frame_start` alone exchanges the writer page with the complete page.
- R10: `upload_go` alone exchanges the complete page with the reader page.
- R11: When `frame_start` and `upload_go` occur in the same cycle, the writer page is exchanged directly with the reader page, and the complete page is unchanged.
- R12: The three page registers always hold three distinct values.
- R13: No read is started while `rd_uploading` is low, even if `rd_need_data` is high and an upload is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_dump_req | input | 1 | Writer FIFO is nearly full and asks for memory time |
| wr_fifo_data | input | DATA_W | Head word of the writer FIFO |
| wr_fifo_pop | output | 1 | Removes the head word of the writer FIFO |
| frame_start | input | 1 | One-cycle pulse: a new sensor frame begins |
| rd_need_data | input | 1 | Reader FIFO is nearly empty and asks for memory time |
| rd_uploading | input | 1 | The host is actively draining the reader FIFO |
| upload_go | input | 1 | One-cycle pulse: start an upload |
| upload_abort | input | 1 | One-cycle pulse: cancel the upload |
| upload_first | input | PTR_W | First word index of the upload |
| upload_last | input | PTR_W | Last word index of the upload |
| rd_fifo_push | output | 1 | Writes `rd_fifo_data` into the reader FIFO |
| rd_fifo_data | output | DATA_W | Word read from memory |
| mem_addr | output | PAGE_W+PTR_W | Memory word address, page in the upper bits |
| mem_wdata | output | DATA_W | Memory write data |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | DATA_W | Memory read data, valid when `mem_done` rises |
| mem_done | input | 1 | Low while an access is in progress |

## Verification
The embedded assertions check on every cycle that:
- the token obeys writer priority and never changes hands directly or while an access is open;
- strobes are single-cycle, mutually exclusive, issued only under the matching owner, and keep a stable address;
- the pointer bounds, loads and clears are respected;
- each page event performs the right exchange and the three pages stay distinct.

Only the bench scenarios can show end-to-end results: the data words and addresses that actually reach memory and the reader FIFO, that an upload yields exactly the requested range, that the pointer continues across separate bursts, and that a waiting side really proceeds once the other side lets go.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

  // Ownership of the shared memory port.
  typedef enum logic [1:0] {
    OWN_FREE   = 2'b00,
    OWN_WRITER = 2'b01,
    OWN_READER = 2'b10
  } owner_e;

endpackage

// File: rtl/fbuf_semaphore.sv
module fbuf_semaphore
  import fbuf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_want,
  input  logic   rd_want,
  input  logic   busy,
  output owner_e owner
);

  owner_e owner_nx;

  always_comb begin
    owner_nx = owner;
    case (owner)
      OWN_FREE: begin
        if (wr_want)      owner_nx = OWN_WRITER;  // writer first: sensor data cannot wait
        else if (rd_want) owner_nx = OWN_READER;
      end
      OWN_WRITER: if (!wr_want && !busy) owner_nx = OWN_FREE;
      OWN_READER: if (!rd_want && !busy) owner_nx = OWN_FREE;
      default:    owner_nx = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner <= OWN_FREE;
    else        owner <= owner_nx;
  end

  assert_writer_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_FREE && wr_want) |=> owner == OWN_WRITER);

  assert_no_direct_w2r_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_WRITER) |=> owner != OWN_READER);

  assert_no_direct_r2w_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_READER) |=> owner != OWN_WRITER);

  assert_hold_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != OWN_FREE && busy) |=> $stable(owner));

endmodule

// File: rtl/fbuf_pointers.sv
module fbuf_pointers #(
  parameter int PTR_W       = 8,
  parameter int FRAME_WORDS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             upload_go,
  input  logic             upload_abort,
  input  logic [PTR_W-1:0] upload_first,
  input  logic [PTR_W-1:0] upload_last,
  input  logic             wr_step,
  input  logic             rd_step,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             rd_active
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(FRAME_WORDS - 1);

  // Saturating advance: the writer never leaves its page.
  function automatic logic [PTR_W-1:0] wr_advance(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? p : p + PTR_W'(1);
  endfunction

  // Reader advance: wraps to zero once the final word has been issued.
  function automatic logic [PTR_W-1:0] rd_advance(input logic [PTR_W-1:0] p,
                                                  input logic [PTR_W-1:0] last);
    return (p == last) ? '0 : p + PTR_W'(1);
  endfunction

  logic rd_final;
  assign rd_final = rd_step && (rd_ptr == upload_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (frame_start) begin
      wr_ptr <= '0;
    end else if (wr_step) begin
      wr_ptr <= wr_advance(wr_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      rd_active <= 1'b0;
    end else if (upload_abort) begin
      rd_ptr    <= '0;
      rd_active <= 1'b0;
    end else if (upload_go) begin
      rd_ptr    <= upload_first;
      rd_active <= 1'b1;
    end else if (rd_step) begin
      rd_ptr    <= rd_advance(rd_ptr, upload_last);
      rd_active <= !rd_final;
    end
  end

  assert_wr_in_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= LAST_IDX);

  assert_frame_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> wr_ptr == '0);

  assert_upload_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upload_go && !upload_abort) |=> (rd_active && rd_ptr == $past(upload_first)));

  assert_upload_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_final && !upload_go && !upload_abort) |=> (!rd_active && rd_ptr == '0));

  assert_abort_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upload_abort |=> (!rd_active && rd_ptr == '0));

endmodule

// File: rtl/fbuf_page_rotor.sv
module fbuf_page_rotor #(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              upload_go,
  output logic [PAGE_W-1:0] pg_wr,
  output logic [PAGE_W-1:0] pg_full,
  output logic [PAGE_W-1:0] pg_rd
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_wr   <= PAGE_W'(0);
      pg_full <= PAGE_W'(1);
      pg_rd   <= PAGE_W'(2);
    end else if (frame_start && upload_go) begin
      pg_wr <= pg_rd;    // fresh frame goes straight to the host
      pg_rd <= pg_wr;
    end else if (frame_start) begin
      pg_wr   <= pg_full;
      pg_full <= pg_wr;
    end else if (upload_go) begin
      pg_rd   <= pg_full;
      pg_full <= pg_rd;
    end
  end

  assert_pages_distinct_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_wr != pg_full && pg_wr != pg_rd && pg_full != pg_rd));

  assert_frame_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !upload_go) |=>
      (pg_wr == $past(pg_full) && pg_full == $past(pg_wr) && $stable(pg_rd)));

  assert_upload_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upload_go && !frame_start) |=>
      (pg_rd == $past(pg_full) && pg_full == $past(pg_rd) && $stable(pg_wr)));

  assert_both_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upload_go && frame_start) |=>
      (pg_rd == $past(pg_wr) && pg_wr == $past(pg_rd) && $stable(pg_full)));

endmodule

// File: rtl/fbuf_access_seq.sv
module fbuf_access_seq
  import fbuf_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  owner_e            owner,
  input  logic              wr_want,
  input  logic              rd_want,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wr_pop,
  output logic              rd_push,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              wr_issue,
  output logic              rd_issue
);

  logic done_q;
  logic rd_kind;
  logic done_rise;
  logic read_land;

  assign wr_issue  = !busy && owner == OWN_WRITER && wr_want;
  assign rd_issue  = !busy && owner == OWN_READER && rd_want;
  assign done_rise = mem_done && !done_q;
  assign read_land = busy && rd_kind && done_rise;
  assign wr_pop    = wr_issue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rd_kind   <= 1'b0;
      mem_wr    <= 1'b0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done_q    <= 1'b1;
      rd_push   <= 1'b0;
      rd_data   <= '0;
    end else begin
      done_q  <= mem_done;
      mem_wr  <= wr_issue;
      mem_rd  <= rd_issue;
      rd_push <= read_land;
      if (read_land) rd_data <= mem_rdata;
      if (wr_issue || rd_issue) begin
        busy     <= 1'b1;
        rd_kind  <= rd_issue;
        mem_addr <= rd_issue ? rd_addr : wr_addr;
        if (wr_issue) mem_wdata <= wr_data;
      end else if (busy && done_rise) begin
        busy <= 1'b0;
      end
    end
  end

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |=> !(mem_wr || mem_rd));

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  assert_write_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> owner == OWN_WRITER);

  assert_read_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> owner == OWN_READER);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_wr && !mem_rd) |-> $stable(mem_addr));

endmodule

// File: rtl/fbuf_page_arbiter.sv
module fbuf_page_arbiter
  import fbuf_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PTR_W       = 8,
  parameter int FRAME_WORDS = 200,
  parameter int PAGE_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_dump_req,
  input  logic [DATA_W-1:0]       wr_fifo_data,
  output logic                    wr_fifo_pop,
  input  logic                    frame_start,
  input  logic                    rd_need_data,
  input  logic                    rd_uploading,
  input  logic                    upload_go,
  input  logic                    upload_abort,
  input  logic [PTR_W-1:0]        upload_first,
  input  logic [PTR_W-1:0]        upload_last,
  output logic                    rd_fifo_push,
  output logic [DATA_W-1:0]       rd_fifo_data,
  output logic [PAGE_W+PTR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    mem_wr,
  output logic                    mem_rd,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    mem_done
);

  localparam int ADDR_W = PAGE_W + PTR_W;

  owner_e            owner;
  logic              wr_want, rd_want, busy;
  logic              wr_issue, rd_issue;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              rd_active;
  logic [PAGE_W-1:0] pg_wr, pg_full, pg_rd;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign wr_want = wr_dump_req;
  assign rd_want = rd_need_data && rd_uploading && rd_active;
  assign wr_addr = {pg_wr, wr_ptr};
  assign rd_addr = {pg_rd, rd_ptr};

  fbuf_semaphore u_sem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_want (wr_want),
    .rd_want (rd_want),
    .busy    (busy),
    .owner   (owner)
  );

  fbuf_pointers #(.PTR_W(PTR_W), .FRAME_WORDS(FRAME_WORDS)) u_ptrs (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .upload_go    (upload_go),
    .upload_abort (upload_abort),
    .upload_first (upload_first),
    .upload_last  (upload_last),
    .wr_step      (wr_issue),
    .rd_step      (rd_issue),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .rd_active    (rd_active)
  );

  fbuf_page_rotor #(.PAGE_W(PAGE_W)) u_pages (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .upload_go   (upload_go),
    .pg_wr       (pg_wr),
    .pg_full     (pg_full),
    .pg_rd       (pg_rd)
  );

  fbuf_access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .owner     (owner),
    .wr_want   (wr_want),
    .rd_want   (rd_want),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .wr_data   (wr_fifo_data),
    .mem_done  (mem_done),
    .mem_rdata (mem_rdata),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wr_pop    (wr_fifo_pop),
    .rd_push   (rd_fifo_push),
    .rd_data   (rd_fifo_data),
    .busy      (busy),
    .wr_issue  (wr_issue),
    .rd_issue  (rd_issue)
  );

  assert_read_needs_host_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(rd_uploading));

  assert_pop_only_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fifo_pop |=> mem_wr);

endmodule

// File: tb/fbuf_page_arbiter_test.sv
`timescale 1ns/1ps
module fbuf_page_arbiter_test;

  localparam int DW  = 16;
  localparam int PW  = 8;
  localparam int FW  = 200;
  localparam int GW  = 3;
  localparam int AW  = PW + GW;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_dump_req = 1'b0;
  logic [DW-1:0] wr_fifo_data;
  logic          wr_fifo_pop;
  logic          frame_start = 1'b0;
  logic          rd_need_data = 1'b0;
  logic          rd_uploading = 1'b0;
  logic          upload_go = 1'b0;
  logic          upload_abort = 1'b0;
  logic [PW-1:0] upload_first = '0;
  logic [PW-1:0] upload_last = '0;
  logic          rd_fifo_push;
  logic [DW-1:0] rd_fifo_data;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_wr, mem_rd;
  logic [DW-1:0] mem_rdata;
  logic          mem_done;

  always #2 clk = ~clk;

  fbuf_page_arbiter #(.DATA_W(DW), .PTR_W(PW), .FRAME_WORDS(FW), .PAGE_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_dump_req(wr_dump_req), .wr_fifo_data(wr_fifo_data),
    .wr_fifo_pop(wr_fifo_pop), .frame_start(frame_start), .rd_need_data(rd_need_data),
    .rd_uploading(rd_uploading), .upload_go(upload_go), .upload_abort(upload_abort),
    .upload_first(upload_first), .upload_last(upload_last), .rd_fifo_push(rd_fifo_push),
    .rd_fifo_data(rd_fifo_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  // ---------------- memory, writer FIFO and reader FIFO models ----------------
  logic [DW-1:0] mem   [0:(1<<AW)-1];
  logic          wrote [0:(1<<AW)-1];
  int wlog_a [0:511];
  int wlog_d [0:511];
  int rlog_a [0:511];
  int plog   [0:511];
  int wn = 0, rn = 0, pn = 0;
  int cnt = 0;
  logic [AW-1:0] raddr = '0;
  logic [DW-1:0] wsrc;

  assign wr_fifo_data = wsrc;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_done  <= 1'b1;
      mem_rdata <= '0;
      cnt       <= 0;
    end else if (mem_wr) begin
      mem[mem_addr]   <= mem_wdata;
      wrote[mem_addr] <= 1'b1;
      wlog_a[wn % 512] <= int'(mem_addr);
      wlog_d[wn % 512] <= int'(mem_wdata);
      wn       <= wn + 1;
      mem_done <= 1'b0;
      cnt      <= LAT;
    end else if (mem_rd) begin
      rlog_a[rn % 512] <= int'(mem_addr);
      rn       <= rn + 1;
      raddr    <= mem_addr;
      mem_done <= 1'b0;
      cnt      <= LAT;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_done  <= 1'b1;
        mem_rdata <= (wrote[raddr] === 1'b1) ? mem[raddr] : DW'(16'h5000 + int'(raddr));
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n)           wsrc <= 16'hA000;
    else if (wr_fifo_pop) wsrc <= wsrc + 16'd1;
  end

  always @(posedge clk) begin
    if (rst_n && rd_fifo_push) begin
      plog[pn % 512] <= int'(rd_fifo_data);
      pn <= pn + 1;
    end
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0, n_fail = 0;
  int ewr = 0, efull = 1, erd = 2;       // expected page registers
  int wdat = 16'hA000;                   // next word the writer FIFO hands out

  function automatic int mk(input int pg, input int p);
    return pg * (1 << PW) + p;
  endfunction

  function automatic int bgval(input int a);
    return (16'h5000 + a) & 16'hFFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_wn(input int target);
    for (int i = 0; i < 4000 && wn < target; i++) @(negedge clk);
  endtask

  task automatic wait_rn(input int target);
    for (int i = 0; i < 4000 && rn < target; i++) @(negedge clk);
  endtask

  task automatic wait_pn(input int target);
    for (int i = 0; i < 4000 && pn < target; i++) @(negedge clk);
  endtask

  task automatic write_words(input int n);
    int target;
    target = wn + n;
    wr_dump_req = 1'b1;
    wait_wn(target);
    wr_dump_req = 1'b0;
    tick(20);
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1; tick(1); frame_start = 1'b0;
    begin int t; t = ewr; ewr = efull; efull = t; end
  endtask

  task automatic pulse_upload(input int first, input int last);
    upload_first = PW'(first); upload_last = PW'(last);
    upload_go = 1'b1; tick(1); upload_go = 1'b0;
    begin int t; t = erd; erd = efull; efull = t; end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    tick(5);
    chk(mem_wr == 1'b0 && mem_rd == 1'b0, "R1 no strobe after reset", int'({mem_wr, mem_rd}), 0);
    chk(wr_fifo_pop == 1'b0 && rd_fifo_push == 1'b0, "R1 no fifo strobes", int'({wr_fifo_pop, rd_fifo_push}), 0);
    chk(wn == 0 && rn == 0, "R1 no access after reset", wn + rn, 0);
  endtask

  task automatic t_first_write();
    int w0;
    w0 = wn;
    write_words(4);
    chk(wn - w0 == 4, "R4 exact write count", wn - w0, 4);
    for (int k = 0; k < 4; k++) begin
      chk(wlog_a[w0 + k] == mk(ewr, k), "R1 R5 write address", wlog_a[w0 + k], mk(ewr, k));
      chk(wlog_d[w0 + k] == wdat + k, "R4 write data", wlog_d[w0 + k], wdat + k);
    end
    wdat += 4;
  endtask

  task automatic t_new_frame();
    int w0;
    pulse_frame();
    w0 = wn;
    write_words(3);
    for (int k = 0; k < 3; k++)
      chk(wlog_a[w0 + k] == mk(ewr, k), "R9 R5 write after frame swap", wlog_a[w0 + k], mk(ewr, k));
    wdat += 3;
  endtask

  task automatic t_upload_basic();
    int r0, p0;
    pulse_upload(1, 3);
    r0 = rn; p0 = pn;
    rd_uploading = 1'b1; rd_need_data = 1'b1;
    wait_pn(p0 + 3);
    tick(40);
    chk(rn - r0 == 3, "R7 read count stops at last", rn - r0, 3);
    chk(pn - p0 == 3, "R6 push count", pn - p0, 3);
    for (int k = 0; k < 3; k++) begin
      chk(rlog_a[r0 + k] == mk(erd, 1 + k), "R10 R6 read address", rlog_a[r0 + k], mk(erd, 1 + k));
      chk(plog[p0 + k] == 16'hA001 + k, "R6 read data", plog[p0 + k], 16'hA001 + k);
    end
    rd_need_data = 1'b0; rd_uploading = 1'b0;
    tick(10);
  endtask

  task automatic t_uploading_gate();
    int r0, p0;
    pulse_upload(0, 1);
    r0 = rn; p0 = pn;
    rd_need_data = 1'b1;
    tick(30);
    chk(rn == r0, "R13 no read while host idle", rn - r0, 0);
    rd_uploading = 1'b1;
    wait_pn(p0 + 2);
    tick(30);
    chk(rn - r0 == 2, "R13 reads resume", rn - r0, 2);
    for (int k = 0; k < 2; k++)
      chk(plog[p0 + k] == bgval(mk(erd, k)), "R6 data from reader page", plog[p0 + k], bgval(mk(erd, k)));
    rd_need_data = 1'b0; rd_uploading = 1'b0;
    tick(10);
  endtask

  task automatic t_abort();
    int r0, r1;
    pulse_upload(10, 100);
    r0 = rn;
    rd_need_data = 1'b1; rd_uploading = 1'b1;
    wait_rn(r0 + 3);
    upload_abort = 1'b1; tick(1); upload_abort = 1'b0;
    tick(15);
    r1 = rn;
    tick(40);
    chk(rn == r1, "R8 reads stop after abort", rn - r1, 0);
    chk(r1 - r0 < 10, "R8 abort cut the upload short", r1 - r0, 4);
    chk(rlog_a[r0] == mk(erd, 10), "R7 load of first index", rlog_a[r0], mk(erd, 10));
    rd_need_data = 1'b0; rd_uploading = 1'b0;
    tick(5);
  endtask

  task automatic t_priority();
    int r0, w0, p1;
    pulse_upload(0, 7);
    r0 = rn; w0 = wn;
    wr_dump_req = 1'b1; rd_need_data = 1'b1; rd_uploading = 1'b1;
    wait_wn(w0 + 3);
    chk(rn == r0, "R2 R3 writer wins and reader waits", rn - r0, 0);
    wr_dump_req = 1'b0;
    wait_rn(r0 + 8);
    tick(30);
    chk(rn - r0 == 8, "R3 reader proceeds after release", rn - r0, 8);
    chk(wlog_a[w0] == mk(ewr, 3), "R5 pointer continues across bursts", wlog_a[w0], mk(ewr, 3));
    chk(rlog_a[r0] == mk(erd, 0), "R10 reader page after upload", rlog_a[r0], mk(erd, 0));
    wdat += wn - w0;
    rd_need_data = 1'b0;
    tick(10);
    // reader holds, writer waits
    pulse_upload(0, 50);
    r0 = rn;
    rd_need_data = 1'b1;
    wait_rn(r0 + 2);
    w0 = wn;
    wr_dump_req = 1'b1;
    tick(20);
    chk(wn == w0, "R3 writer waits while reader holds", wn - w0, 0);
    p1 = rn;
    rd_need_data = 1'b0;
    wait_wn(w0 + 1);
    wr_dump_req = 1'b0;
    tick(20);
    chk(wn - w0 >= 1 && rn - p1 <= 1, "R3 writer proceeds after release", wn - w0, 1);
    wdat += wn - w0;
    upload_abort = 1'b1; tick(1); upload_abort = 1'b0;
    rd_uploading = 1'b0;
    tick(10);
  endtask

  task automatic t_both_events();
    int w0, pa, pb, t;
    upload_first = '0; upload_last = '0;
    frame_start = 1'b1; upload_go = 1'b1; tick(1);
    frame_start = 1'b0; upload_go = 1'b0;
    t = ewr; ewr = erd; erd = t;
    w0 = wn;
    write_words(1);
    pa = wlog_a[w0] >> PW;
    chk(wlog_a[w0] == mk(ewr, 0), "R11 writer takes reader page", wlog_a[w0], mk(ewr, 0));
    pulse_frame();
    w0 = wn;
    write_words(1);
    pb = wlog_a[w0] >> PW;
    chk(wlog_a[w0] == mk(ewr, 0), "R11 complete page untouched", wlog_a[w0], mk(ewr, 0));
    chk(pa != pb && pa < 3 && pb < 3, "R12 pages distinct", pb, pa);
    wdat += 2;
  endtask

  task automatic t_saturate();
    int w0;
    pulse_frame();
    w0 = wn;
    write_words(FW + 5);
    chk(wlog_a[w0 + FW - 2] == mk(ewr, FW - 2), "R5 pointer below limit", wlog_a[w0 + FW - 2], mk(ewr, FW - 2));
    for (int k = FW - 1; k < FW + 5; k++)
      chk(wlog_a[w0 + k] == mk(ewr, FW - 1), "R5 pointer saturates", wlog_a[w0 + k], mk(ewr, FW - 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    t_reset();
    t_first_write();
    t_new_frame();
    t_upload_basic();
    t_uploading_gate();
    t_abort();
    t_priority();
    t_both_events();
    t_saturate();
    tick(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule